// File: doc/BRIEF.md
# Display Pixel Wire Packer

This block takes a stream of 24-bit RGB pixels and turns it into the byte stream that a serial display link carries to a panel controller. Each 8-bit colour component is cut down to the width the chosen layout needs by keeping its top bits. The block then puts the components in RGB or BGR order and emits one, two or three bytes per pixel. In the 3-bit layouts it emits one byte per pair of pixels.

The layout is held in a small format register. It resets to the RGB 16-bit layout and is written through `cfg_we`/`cfg_fmt`. The register is read when a pixel is accepted and no pixel pair is half built. A pair that has been started keeps the format it began with. Pixels enter on a ready/valid port and carry a frame-end flag. Bytes leave on a ready/valid port with `out_last`. If a frame ends on the first pixel of a pair, the block pads the byte and sends it at once. Bits marked as unused in a layout are driven as zero.

Top module: `px_wire_packer`

## Requirements
- R1: Format code 4 (RGB, 16-bit) sends two bytes per pixel: {R[7:3],G[7:5]} first, then {G[4:2],B[7:3]}.
- R2: Format code 5 (BGR, 16-bit) sends {B[7:3],G[7:5]} first, then {G[4:2],R[7:3]}.
- R3: Format codes 6 (RGB) and 7 (BGR) send three bytes per pixel. Each byte holds one component's bits [7:2] in byte bits 7:2, with bits 1:0 zero. The order is R, G, B for code 6 and B, G, R for code 7.
- R4: Format code 0 packs two pixels per byte as {2'b00, first[2:0], second[2:0]}. Each 3-bit group is {R[7],G[7],B[7]}.
- R5: Format code 2 packs two pixels per byte as {1'b0, first[2:0], 1'b0, second[2:0]}.
- R6: Format codes 1 and 3 are the BGR versions of codes 0 and 2. Each 3-bit group is {B[7],G[7],R[7]}.
- R7: In a 3-bit format, a pixel that ends a frame while no pair is open is sent at once as the first pixel of a byte. The second slot of that byte is zero.
- R8: `out_last` is high only on the final byte that carries the pixel flagged `in_last`.
- R9: After reset the format is code 4.
- R10: A format write made while a pair is half built does not change that pair's byte. The new format applies from the next pixel group.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values on the next cycle.
- R12: `in_ready` is high when no output byte is pending, including right after reset. It is low while any byte is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the format register |
| cfg_fmt | input | 3 | Format code (bit 0 selects BGR; bits 2:1 select 3-bit option 1, 3-bit option 2, 16-bit or 18-bit) |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_rgb | input | 24 | Pixel as R[23:16], G[15:8], B[7:0] |
| in_last | input | 1 | Pixel ends the frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | 8 | Wire byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
A pixel accepted at a clock edge shows its first byte on `out_valid`/`out_data` at that same edge. Each later byte moves up one edge after the previous byte's handshake. The first pixel of a 3-bit pair produces no byte; the byte appears at the edge that accepts the second pixel. The scoreboard does not count cycles. It queues the expected bytes when the driver's pixel is accepted and pops one entry on every output handshake, sampled at the falling edge, so arbitrary sink stalls do not disturb the order. The stall-hold and ready-blocking checks compare values one falling edge after a stall or acceptance, which is exactly one register stage later.

// File: rtl/px_wire_packer.sv
module px_wire_packer #(
  parameter logic [2:0] FMT_RESET = 3'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_fmt,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [23:0] in_rgb,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last
);

  logic [2:0]  fmt_q, lock_q, held_px_q;
  logic        half_q, last_q;
  logic [23:0] shreg_q;
  logic [1:0]  cnt_q;

  wire [2:0] use_fmt = half_q ? lock_q : fmt_q;
  wire       swap    = use_fmt[0];
  wire [7:0] c_r = in_rgb[23:16];
  wire [7:0] c_g = in_rgb[15:8];
  wire [7:0] c_b = in_rgb[7:0];
  wire [7:0] c_lead  = swap ? c_b : c_r;
  wire [7:0] c_trail = swap ? c_r : c_b;

  wire [2:0]  px3  = {c_lead[7], c_g[7], c_trail[7]};
  wire [15:0] w16  = {c_lead[7:3], c_g[7:2], c_trail[7:3]};
  wire [23:0] w18  = {c_lead[7:2], 2'b00, c_g[7:2], 2'b00, c_trail[7:2], 2'b00};
  wire [2:0]  hi3  = half_q ? held_px_q : px3;
  wire [2:0]  lo3  = half_q ? px3 : 3'b000;
  wire [7:0]  pair = use_fmt[1] ? {1'b0, hi3, 1'b0, lo3} : {2'b00, hi3, lo3};

  assign in_ready  = (cnt_q == 2'd0);
  assign out_valid = (cnt_q != 2'd0);
  assign out_data  = shreg_q[23:16];
  assign out_last  = last_q && (cnt_q == 2'd1);

  wire take = in_valid && in_ready;
  wire give = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q     <= FMT_RESET;
      lock_q    <= FMT_RESET;
      held_px_q <= 3'b000;
      half_q    <= 1'b0;
      last_q    <= 1'b0;
      shreg_q   <= '0;
      cnt_q     <= 2'd0;
    end else begin
      if (cfg_we) fmt_q <= cfg_fmt;
      if (take) begin
        if (use_fmt[2]) begin
          last_q <= in_last;
          if (use_fmt[1]) begin
            shreg_q <= w18;
            cnt_q   <= 2'd3;
          end else begin
            shreg_q <= {w16, 8'h00};
            cnt_q   <= 2'd2;
          end
        end else if (half_q || in_last) begin
          shreg_q <= {pair, 16'h0000};
          cnt_q   <= 2'd1;
          last_q  <= in_last;
          half_q  <= 1'b0;
        end else begin
          half_q    <= 1'b1;
          held_px_q <= px3;
          lock_q    <= fmt_q;
        end
      end else if (give) begin
        shreg_q <= {shreg_q[15:0], 8'h00};
        cnt_q   <= cnt_q - 2'd1;
      end
    end
  end

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  p_busy_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_last_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_open_pair_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    half_q |-> !out_valid);

  p_frame_end_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (give && out_last) |=> (!out_valid && !half_q));

  p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && use_fmt[2] && use_fmt[1]) |=> (out_data[1:0] == 2'b00));

endmodule

// File: tb/px_wire_packer_bench.sv
`timescale 1ns/1ps
module px_wire_packer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_fmt = 3'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_rgb = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        out_last;

  always #10 clk = ~clk;

  px_wire_packer u_px_wire_packer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fmt(cfg_fmt),
    .in_valid(in_valid), .in_ready(in_ready), .in_rgb(in_rgb), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last));

  int checks = 0;
  int errors = 0;
  logic [8:0] q_exp[$];
  string      q_tag[$];

  int         fmt_b = 4;
  int         lock_b = 4;
  bit         half_b = 0;
  logic [2:0] held_b = 3'b000;

  int         rdy_mode = 0;
  logic [7:0] lfsr = 8'hA5;

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : lfsr[0];
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(logic [7:0] d, bit l, string tag);
    q_exp.push_back({l, d});
    q_tag.push_back(tag);
  endtask

  // scoreboard monitor
  logic       prev_stall = 1'b0;
  logic [8:0] prev_val = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && {out_last, out_data} == prev_val, "R11 hold",
              {23'd0, out_last, out_data}, {23'd0, prev_val});
      if (out_valid && out_ready) begin
        if (q_exp.size() == 0) begin
          check(0, "R8 unexpected byte", {23'd0, out_last, out_data}, 32'd0);
        end else begin
          logic [8:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          check({out_last, out_data} == e, t, {23'd0, out_last, out_data}, {23'd0, e});
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_val   = {out_last, out_data};
    end
  end

  task automatic set_fmt(int f);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_fmt = f[2:0];
    @(negedge clk);
    cfg_we = 1'b0;
    fmt_b = f;
  endtask

  task automatic send_pix(logic [23:0] p, bit l, string tag);
    int uf;
    logic [7:0] r, g, b, a, z;
    logic [15:0] w;
    logic [2:0] t3, hi, lo;
    uf = half_b ? lock_b : fmt_b;
    r = p[23:16]; g = p[15:8]; b = p[7:0];
    a = uf[0] ? b : r;
    z = uf[0] ? r : b;
    if (uf >= 6) begin
      push({a[7:2], 2'b00}, 0, tag);
      push({g[7:2], 2'b00}, 0, tag);
      push({z[7:2], 2'b00}, l, tag);
    end else if (uf >= 4) begin
      w = {a[7:3], g[7:2], z[7:3]};
      push(w[15:8], 0, tag);
      push(w[7:0], l, tag);
    end else begin
      t3 = {a[7], g[7], z[7]};
      if (!half_b && !l) begin
        half_b = 1; held_b = t3; lock_b = uf;
      end else begin
        hi = half_b ? held_b : t3;
        lo = half_b ? t3 : 3'b000;
        push((uf >= 2) ? {1'b0, hi, 1'b0, lo} : {2'b00, hi, lo}, l, tag);
        half_b = 0;
      end
    end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_rgb = p; in_last = l;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      if (q_exp.size() == 0 && !out_valid) break;
      @(negedge clk);
    end
    check(q_exp.size() == 0, "R8 queue drained", q_exp.size(), 0);
  endtask

  initial begin
    #(100000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R12 ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R12 idle after reset", out_valid, 0);

    // R9 default format is 16-bit RGB; R1
    send_pix(24'hF0A5C3, 1, "R9 default fmt");
    send_pix(24'h123456, 0, "R1 rgb565");
    send_pix(24'hFFFFFF, 0, "R1 rgb565 ones");
    send_pix(24'h8040E8, 1, "R1 rgb565 last R8");
    drain();

    set_fmt(5);
    send_pix(24'hF0A5C3, 0, "R2 bgr565");
    send_pix(24'h1F7E09, 1, "R2 bgr565 last");
    set_fmt(6);
    send_pix(24'hFFC381, 0, "R3 rgb666");
    send_pix(24'h0355AA, 1, "R3 rgb666 last");
    set_fmt(7);
    send_pix(24'hFFC381, 1, "R3 bgr666");
    drain();

    set_fmt(0);
    send_pix(24'h80FF00, 0, "R4 opt1 pair");
    send_pix(24'h008080, 0, "R4 opt1 pair");
    send_pix(24'hFF0000, 0, "R4 opt1 pair last");
    send_pix(24'h0000FF, 1, "R4 opt1 pair last R8");
    set_fmt(1);
    send_pix(24'h80FF00, 0, "R6 bgr opt1");
    send_pix(24'h00007F, 1, "R6 bgr opt1");
    set_fmt(2);
    send_pix(24'h808080, 0, "R5 opt2 pair");
    send_pix(24'h800080, 1, "R5 opt2 pair");
    set_fmt(3);
    send_pix(24'h800000, 0, "R6 bgr opt2");
    send_pix(24'h0080FF, 1, "R6 bgr opt2");
    drain();

    set_fmt(0);
    send_pix(24'hFF80FF, 1, "R7 odd pad opt1");
    set_fmt(2);
    send_pix(24'h80FF80, 1, "R7 odd pad opt2");
    set_fmt(3);
    send_pix(24'h8000FF, 0, "R7 pair then odd");
    send_pix(24'h808000, 0, "R7 pair then odd");
    send_pix(24'h000080, 1, "R7 odd pad bgr opt2");
    drain();

    // R10: format write while a pair is open
    set_fmt(0);
    send_pix(24'h800000, 0, "R10 locked pair");
    set_fmt(4);
    send_pix(24'h00FF00, 0, "R10 locked pair");
    send_pix(24'hABCDEF, 1, "R10 new fmt applies");
    drain();

    // R11 random backpressure
    rdy_mode = 1;
    set_fmt(6);
    for (int i = 0; i < 8; i++)
      send_pix(24'h13579B + 24'h2468AC * i, i == 7, "R11 stall 666");
    set_fmt(5);
    for (int i = 0; i < 6; i++)
      send_pix(24'hFEDCBA - 24'h111111 * i, i == 5, "R11 stall 565");
    drain();

    // R12 busy blocks input
    rdy_mode = 2;
    set_fmt(4);
    send_pix(24'h0F0F0F, 1, "R12 busy pixel");
    @(negedge clk);
    check(in_ready == 1'b0, "R12 busy not ready", in_ready, 0);
    check(out_valid == 1'b1, "R12 byte pending", out_valid, 1);
    rdy_mode = 0;
    drain();
    check(in_ready == 1'b1, "R12 ready after drain", in_ready, 1);

    summary();
    $finish;
  end
endmodule